// File: doc/BRIEF.md
# Carry-free signed-digit adder

This block adds two radix-2 redundant signed-digit numbers of `N_DIGITS` digits each. Every digit is -1, 0 or +1, and digit i weighs 2^i. Because a value can be written in more than one way, no carry has to ripple along the word. Three local rewrite steps produce the sum, and each step looks only at one digit position and the position just below it. The depth of the logic is therefore the same for any operand width.

Step one splits each pair sum x_i + y_i into a transfer digit for position i+1 and a weight digit for position i. Step two applies a second rewrite, with a different mapping, to each transfer-plus-weight pair. Step three adds the remaining pairs, and every one of those sums is guaranteed to be a single legal digit. The parameter `STEP_REGS` places a register after step one and another after step two, or joins all three steps into one combinational path. The result register is always present. The sum has `N_DIGITS + 2` digits so that both shifted-out transfer digits fit.

Top module: `sd_cf_adder`

## Requirements
- R1: Each digit travels as a 2-bit code: 2'b00 is 0, 2'b01 is +1 and 2'b11 is -1. The final step never receives a digit pair whose sum lies outside -1..+1, so no output digit is ever the illegal code 2'b10.
- R2: When `sum_vld` is high, the value of `sum_dig` (the sum of digit_i times 2^i over all `N_DIGITS + 2` digits) equals value(`op_a`) + value(`op_b`) for the operands accepted with the matching `in_vld`.
- R3: A result appears exactly 1 + 2*`STEP_REGS` cycles after its `in_vld` cycle, whatever the value of `N_DIGITS`. One new operand pair is accepted on every cycle.
- R4: A synchronous active-high `rst` clears `sum_vld` and all of `sum_dig` to 0 on the next edge, even while `in_vld` is high.
- R5: In a cycle with `sum_vld` low, `sum_dig` keeps the last result. Operands presented without `in_vld` leave the output unchanged.
- R6: Any legal encoding of an operand is accepted. For example, 4 written as 0,1,0,0 (most significant digit first) and 4 written as 1,-1,0,0 both give correct sums.
- R7: Extreme operands give exact sums: all digits +1 twice gives 2*(2^N-1), all digits -1 twice gives -2*(2^N-1), and all +1 plus all -1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands on `op_a`/`op_b` are valid this cycle |
| op_a | input | 2*N_DIGITS | First operand, digit i in bits [2i+1:2i] |
| op_b | input | 2*N_DIGITS | Second operand, same layout |
| sum_vld | output | 1 | `sum_dig` holds a new result this cycle |
| sum_dig | output | 2*(N_DIGITS+2) | Signed-digit sum, digit i in bits [2i+1:2i] |

## Verification
The bench sweeps every pair of 4-digit operands, 6561 in all, so every mix of redundant encodings, every sign and every pattern of neighbouring digits is seen. If the two rewrite mappings were swapped or altered, the final step would see same-sign pairs and produce an illegal code or a wrong value. A transfer digit shifted into the wrong position would show up as an error of a power of two. The stream has idle gaps and starts with operands held valid during reset. A wrong valid delay, an output register that loads while idle, or a reset that does not dominate would each show up as a latency, hold or reset mismatch.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef logic [1:0] sd_code_t;

  localparam sd_code_t SD_ZERO = 2'b00;
  localparam sd_code_t SD_POS  = 2'b01;
  localparam sd_code_t SD_NEG  = 2'b11;

  // Numeric value of one digit code; the illegal code reads as zero.
  function automatic logic signed [2:0] sd_to_int(input sd_code_t c);
    case (c)
      SD_POS:  return 3'sd1;
      SD_NEG:  return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  // Code for a value in -1..+1.
  function automatic sd_code_t sd_from_int(input logic signed [2:0] v);
    if (v == 3'sd1)       return SD_POS;
    else if (v == -3'sd1) return SD_NEG;
    else                  return SD_ZERO;
  endfunction
endpackage

// File: rtl/sd_rewrite.sv
// One rewrite step: each pair sum a_i + b_i becomes 2*xfer_(i+1) + keep_i.
// SECOND selects the second-step mapping.
module sd_rewrite
  import sd_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit SECOND = 1'b0
) (
  input  logic [2*WIDTH-1:0]     a,
  input  logic [2*WIDTH-1:0]     b,
  output logic [2*(WIDTH+1)-1:0] xfer,
  output logic [2*(WIDTH+1)-1:0] keep
);
  assign xfer[1:0]           = SD_ZERO;
  assign keep[2*WIDTH +: 2]  = SD_ZERO;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    logic signed [2:0] pair;
    sd_code_t          tc;
    sd_code_t          wc;

    assign pair = sd_to_int(a[2*i +: 2]) + sd_to_int(b[2*i +: 2]);

    if (SECOND) begin : g_second
      always_comb begin
        case (pair)
          3'sd2:   begin tc = SD_POS;  wc = SD_ZERO; end
          3'sd1:   begin tc = SD_ZERO; wc = SD_POS;  end
          -3'sd1:  begin tc = SD_ZERO; wc = SD_NEG;  end
          -3'sd2:  begin tc = SD_NEG;  wc = SD_ZERO; end
          default: begin tc = SD_ZERO; wc = SD_ZERO; end
        endcase
      end
    end else begin : g_first
      always_comb begin
        case (pair)
          3'sd2:   begin tc = SD_POS;  wc = SD_ZERO; end
          3'sd1:   begin tc = SD_POS;  wc = SD_NEG;  end
          -3'sd1:  begin tc = SD_NEG;  wc = SD_POS;  end
          -3'sd2:  begin tc = SD_NEG;  wc = SD_ZERO; end
          default: begin tc = SD_ZERO; wc = SD_ZERO; end
        endcase
      end
    end

    assign xfer[2*(i+1) +: 2] = tc;
    assign keep[2*i +: 2]     = wc;
  end
endmodule

// File: rtl/sd_merge.sv
// Final step: digit-wise sum of two vectors whose pair sums stay in -1..+1.
module sd_merge
  import sd_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic [2*WIDTH-1:0] t,
  input  logic [2*WIDTH-1:0] w,
  output logic [2*WIDTH-1:0] s
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    assign s[2*i +: 2] = sd_from_int(sd_to_int(t[2*i +: 2]) + sd_to_int(w[2*i +: 2]));
  end
endmodule

// File: rtl/sd_stage_reg.sv
// Optional pipeline register with valid. HOLD_IDLE keeps the data while idle.
module sd_stage_reg #(
  parameter int W          = 8,
  parameter bit REGISTERED = 1'b1,
  parameter bit HOLD_IDLE  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] d_o
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_o <= 1'b0;
        d_o   <= '0;
      end else begin
        vld_o <= vld_i;
        if (vld_i || !HOLD_IDLE) d_o <= d_i;
      end
    end
  end else begin : g_wire
    assign vld_o = vld_i;
    assign d_o   = d_i;
  end
endmodule

// File: rtl/sd_cf_adder.sv
module sd_cf_adder #(
  parameter int N_DIGITS  = 4,
  parameter bit STEP_REGS = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  input  logic [2*N_DIGITS-1:0]     op_a,
  input  logic [2*N_DIGITS-1:0]     op_b,
  output logic                      sum_vld,
  output logic [2*(N_DIGITS+2)-1:0] sum_dig
);
  localparam int W1 = N_DIGITS + 1;
  localparam int W2 = N_DIGITS + 2;

  logic [2*W1-1:0] t1, w1, t1_q, w1_q;
  logic [2*W2-1:0] t2, w2, mrg_t, mrg_w, mrg_s;
  logic            vld1, vld2;

  sd_rewrite #(.WIDTH(N_DIGITS), .SECOND(1'b0)) u_step1 (
    .a(op_a), .b(op_b), .xfer(t1), .keep(w1)
  );

  sd_stage_reg #(.W(4*W1), .REGISTERED(STEP_REGS), .HOLD_IDLE(1'b0)) u_reg1 (
    .clk(clk), .rst(rst), .vld_i(in_vld), .d_i({t1, w1}),
    .vld_o(vld1), .d_o({t1_q, w1_q})
  );

  sd_rewrite #(.WIDTH(W1), .SECOND(1'b1)) u_step2 (
    .a(t1_q), .b(w1_q), .xfer(t2), .keep(w2)
  );

  sd_stage_reg #(.W(4*W2), .REGISTERED(STEP_REGS), .HOLD_IDLE(1'b0)) u_reg2 (
    .clk(clk), .rst(rst), .vld_i(vld1), .d_i({t2, w2}),
    .vld_o(vld2), .d_o({mrg_t, mrg_w})
  );

  sd_merge #(.WIDTH(W2)) u_step3 (
    .t(mrg_t), .w(mrg_w), .s(mrg_s)
  );

  sd_stage_reg #(.W(2*W2), .REGISTERED(1'b1), .HOLD_IDLE(1'b1)) u_out (
    .clk(clk), .rst(rst), .vld_i(vld2), .d_i(mrg_s),
    .vld_o(sum_vld), .d_o(sum_dig)
  );
endmodule

// File: rtl/sd_cf_adder_chk.sv
module sd_cf_adder_chk
  import sd_pkg::*;
#(
  parameter int N_DIGITS  = 4,
  parameter bit STEP_REGS = 1'b1
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_vld,
  input logic [2*N_DIGITS-1:0]     op_a,
  input logic [2*N_DIGITS-1:0]     op_b,
  input logic                      sum_vld,
  input logic [2*(N_DIGITS+2)-1:0] sum_dig,
  input logic [2*(N_DIGITS+2)-1:0] mrg_t,
  input logic [2*(N_DIGITS+2)-1:0] mrg_w
);
  localparam int W2  = N_DIGITS + 2;
  localparam int LAT = 1 + 2 * int'(STEP_REGS);

  int   in_sum, out_sum;
  logic bad_code, bad_pair;
  logic [2:0] since_rst;

  always_comb begin
    in_sum = 0;
    for (int i = 0; i < N_DIGITS; i++)
      in_sum += (int'(sd_to_int(op_a[2*i +: 2])) + int'(sd_to_int(op_b[2*i +: 2]))) * (1 << i);
    out_sum  = 0;
    bad_code = 1'b0;
    bad_pair = 1'b0;
    for (int i = 0; i < W2; i++) begin
      out_sum += int'(sd_to_int(sum_dig[2*i +: 2])) * (1 << i);
      if (sum_dig[2*i +: 2] == 2'b10) bad_code = 1'b1;
      if ((mrg_t[2*i +: 2] == mrg_w[2*i +: 2]) && (mrg_t[2*i +: 2] != SD_ZERO)) bad_pair = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                since_rst <= '0;
    else if (since_rst < 7) since_rst <= since_rst + 3'd1;
  end

  // R1: output codes legal; final-step pairs never share a nonzero sign
  a_r1_legal_out: assert property (@(posedge clk) disable iff (rst) sum_vld |-> !bad_code);
  a_r1_merge_range: assert property (@(posedge clk) disable iff (rst) !bad_pair);

  // R2: exact value after the fixed latency
  if (STEP_REGS) begin : g_lat3
    a_r2_value: assert property (@(posedge clk) disable iff (rst)
      sum_vld |-> out_sum == $past(in_sum, 3));
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 3'(LAT)) |-> sum_vld == $past(in_vld, 3));
  end else begin : g_lat1
    a_r2_value: assert property (@(posedge clk) disable iff (rst)
      sum_vld |-> out_sum == $past(in_sum, 1));
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 3'(LAT)) |-> sum_vld == $past(in_vld, 1));
  end

  // R4: reset clears the output stage
  a_r4_reset_clears: assert property (@(posedge clk) rst |=> (!sum_vld && sum_dig == '0));

  // R5: output holds while no result is presented
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!sum_vld && since_rst >= 3'd1) |-> $stable(sum_dig));
endmodule

bind sd_cf_adder sd_cf_adder_chk #(.N_DIGITS(N_DIGITS), .STEP_REGS(STEP_REGS)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
  .sum_vld(sum_vld), .sum_dig(sum_dig), .mrg_t(mrg_t), .mrg_w(mrg_w)
);

// File: tb/sd_cf_adder_tb.sv
`timescale 1ns/1ps
module sd_cf_adder_tb;
  localparam int  N    = 4;
  localparam bit  SREG = 1'b1;
  localparam int  LAT  = 1 + 2 * int'(SREG);
  localparam int  OW   = N + 2;
  localparam int  NCOMB = 81;  // 3^N
  localparam int  DEPTH = 8192;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_vld = 1'b0;
  logic [2*N-1:0]    op_a = '0, op_b = '0;
  logic              sum_vld;
  logic [2*OW-1:0]   sum_dig;

  int checks = 0, fails = 0, cyc = 0;
  int wr = 0, rd = 0;
  int    exp_val [0:DEPTH-1];
  int    exp_cyc [0:DEPTH-1];
  string exp_req [0:DEPTH-1];
  logic [2*OW-1:0] last_res = '0;
  logic mon_en = 1'b0;

  sd_cf_adder #(.N_DIGITS(N), .STEP_REGS(SREG)) u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .sum_vld(sum_vld), .sum_dig(sum_dig)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int dval(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
  endfunction

  function automatic int vec_val(input logic [2*OW-1:0] v, input int nd);
    int s = 0;
    for (int i = 0; i < nd; i++) s += dval(v[2*i +: 2]) * (1 << i);
    return s;
  endfunction

  // Base-3 index to operand: 0 -> 0, 1 -> +1, 2 -> -1 per digit.
  function automatic logic [2*N-1:0] enc_idx(input int idx);
    logic [2*N-1:0] v = '0;
    int r = idx;
    for (int i = 0; i < N; i++) begin
      v[2*i +: 2] = (r % 3 == 0) ? 2'b00 : (r % 3 == 1) ? 2'b01 : 2'b11;
      r = r / 3;
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2*N-1:0] a, input logic [2*N-1:0] b, input string req);
    @(negedge clk);
    in_vld = 1'b1;
    op_a = a;
    op_b = b;
    exp_val[wr] = vec_val({4'b0, a}, N) + vec_val({4'b0, b}, N);
    exp_cyc[wr] = cyc;
    exp_req[wr] = req;
    wr++;
  endtask

  task automatic idle(input logic [2*N-1:0] junk);
    @(negedge clk);
    in_vld = 1'b0;
    op_a = junk;
    op_b = ~junk;
  endtask

  // Result monitor: R1 legal codes, R2 value, R3 latency, R5 hold.
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (sum_vld) begin
        bit legal = 1'b1;
        for (int i = 0; i < OW; i++) if (sum_dig[2*i +: 2] == 2'b10) legal = 1'b0;
        check(legal, "R1", "illegal digit code in result", int'(legal), 1);
        if (rd < wr) begin
          check(vec_val(sum_dig, OW) == exp_val[rd], exp_req[rd], "sum value",
                vec_val(sum_dig, OW), exp_val[rd]);
          check(cyc - exp_cyc[rd] == LAT, "R3", "latency", cyc - exp_cyc[rd], LAT);
        end else begin
          check(1'b0, "R3", "unexpected result", rd, wr);
        end
        rd++;
        last_res = sum_dig;
      end else begin
        check(sum_dig == last_res, "R5", "output changed while idle",
              vec_val(sum_dig, OW), vec_val(last_res, OW));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int slot = 0;
    // R4: reset dominates valid operands
    @(negedge clk);
    in_vld = 1'b1;
    op_a = 8'b01010101;
    op_b = 8'b01010101;
    repeat (4) @(negedge clk);
    check(sum_vld == 1'b0, "R4", "sum_vld in reset", int'(sum_vld), 0);
    check(sum_dig == '0, "R4", "sum_dig in reset", vec_val(sum_dig, OW), 0);
    in_vld = 1'b0;
    rst = 1'b0;
    mon_en = 1'b1;

    // R6: two encodings of 4 (0,1,0,0 and 1,-1,0,0)
    issue(8'b00_01_00_00, 8'b01_11_00_00, "R6");
    issue(8'b01_11_00_00, 8'b01_11_00_00, "R6");
    // R7: extremes
    issue(8'b01010101, 8'b01010101, "R7");
    issue(8'b11111111, 8'b11111111, "R7");
    issue(8'b01010101, 8'b11111111, "R7");
    idle(8'hA5);
    idle(8'h3C);

    // R2: exhaustive sweep, back to back with occasional gaps
    for (int ia = 0; ia < NCOMB; ia++) begin
      for (int ib = 0; ib < NCOMB; ib++) begin
        issue(enc_idx(ia), enc_idx(ib), "R2");
        slot++;
        if (slot % 13 == 0) idle(enc_idx(ib));
      end
    end
    idle('0);
    repeat (LAT + 3) @(negedge clk);
    check(rd == wr, "R3", "results received", rd, wr);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule